// File: doc/BRIEF.md
# Four-Lane Transmit Character Capture Stage

This block sits in front of a four-lane serial transmitter. On every clock it takes one character per lane, made of eight data bits and two control bits, and passes it on to the next stage. A two-bit mode input says what the next stage does with it. When encoding is off, the ten bits are already a finished line character, with the control pair as the top two bits. When encoding is on, the control pair travels with the data byte to choose the line character. A single special-character select bit, shared by all lanes, is captured alongside the characters when the mode asks for it. When the mode does not ask for it, the select bit is forced to zero.

Lane timing is set by a static strap. In shared-clock mode, all four lanes are sampled on the core clock and the select bit may change on any cycle. In per-lane-clock mode, each lane writes on its own clock into a small dual-clock FIFO. The FIFOs are drained together on the core clock, so characters from all lanes stay aligned. The select bit is sampled on the first lane's clock and stored in that lane's FIFO. It reaches the output with the very character it was sampled with. Each lane reports a sticky error bit when its FIFO overflows or runs dry.

Top module: `txin_stage`

## Requirements
- R1: In shared-clock mode (`split_clk`=0), one clock after an edge, lane i of `out_word` (bits 10i+9..10i) holds {control pair, data byte} sampled at that edge, and `out_valid` is 1.
- R2: When `tx_mode[1]`=0, `out_bypass` is 1 one clock later, and the word is a pre-encoded character whose bits 9..8 are the control pair.
- R3: When `tx_mode[1]`=1, `out_bypass` is 0 one clock later, and the data byte and control pair are delivered unchanged for encoding.
- R4: When `tx_mode[0]`=0 in shared-clock mode, `out_sel` equals the `sel_in` value sampled one clock earlier, and may change on every cycle.
- R5: When `tx_mode[0]`=1, `out_sel` is 0 one clock later, whatever `sel_in` is.
- R6: In per-lane-clock mode, every cycle with `out_valid`=1 carries the k-th character written on every lane, in write order. No output is produced while any lane FIFO is empty.
- R7: In per-lane-clock mode, `out_sel` equals the `sel_in` value that was sampled on lane 0's clock together with the lane 0 character now at the output.
- R8: While `rst_n` is low, `out_valid`, `out_word`, `out_sel`, `out_bypass` and `fifo_err` are all 0 after the first clock edge.
- R9: A write into a full lane FIFO is dropped and sets that lane's `fifo_err` bit. The bit stays set until reset.
- R10: After streaming has started, a lane whose FIFO is empty when the lanes are due to be read sets its `fifo_err` bit, and `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; output and FIFO read domain |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every clock domain |
| split_clk | input | 1 | Static strap: 1 selects per-lane clocks with FIFOs, 0 selects the shared clock |
| tx_mode | input | 2 | Bit 1: encoder on; bit 0: select bit ignored |
| lane_clk | input | LANES | Per-lane write clocks, used when `split_clk`=1 |
| lane_data | input | LANES*8 | Data byte per lane, lane i at bits 8i+7..8i |
| lane_ctl | input | LANES*2 | Control pair per lane, lane i at bits 2i+1..2i |
| sel_in | input | 1 | Shared special-character select |
| out_valid | output | 1 | The output word holds a new character set |
| out_word | output | LANES*10 | Per-lane {control pair, data byte} |
| out_sel | output | 1 | Select bit that goes with the output word |
| out_bypass | output | 1 | 1 when the word is pre-encoded (encoder off) |
| fifo_err | output | LANES | Sticky per-lane overflow or underflow flag |

## Verification
The bench uses the default parameters: four lanes, a FIFO depth of eight, eight data bits and two control bits. A depth of eight absorbs the two-stage pointer synchronizer lag, so that lanes running at the same rate but out of phase can stream without a break. The four lane clocks are offset from each other and from the core clock. As a result, the alignment check in per-lane mode tests real clock crossings. Gating one lane clock leaves that FIFO starved and lets the others fill, which reaches both underflow and overflow within a few dozen cycles.

// File: rtl/txin_pkg.sv
// Shared constants and mode decoding for the transmit capture stage.
// Assumes the 2-bit mode: bit 1 enables encoding, bit 0 ignores the select bit.
package txin_pkg;

    localparam int TXIN_LANES  = 4;
    localparam int TXIN_DATA_W = 8;
    localparam int TXIN_CTL_W  = 2;
    localparam int TXIN_DEPTH  = 8;

    // True when the word goes to the encoder rather than straight to the line.
    function automatic logic encoder_on(input logic [1:0] mode);
        return mode[1];
    endfunction

    // True when the shared select bit is captured and passed on.
    function automatic logic select_on(input logic [1:0] mode);
        return ~mode[0];
    endfunction

endpackage

// File: rtl/txin_sync2.sv
// Two-flop synchronizer for Gray pointers and single-bit flags.
// Assumes multi-bit inputs change by at most one bit per source clock.
module txin_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/txin_lane_fifo.sv
// Dual-clock FIFO for one lane, using Gray-coded pointers.
// Writes are dropped when the FIFO is full, and a sticky overflow flag is carried to the read domain.
// Assumes DEPTH is a power of two and at least 4.
module txin_lane_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 8
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             ovf
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rbin, rgray, rgray_w, wgray_r;
    logic [AW:0] wbin_nx, rbin_nx;
    logic        full, ovf_w;

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;
    assign full    = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    assign empty   = (rgray == wgray_r);
    assign rdata   = mem[rbin[AW-1:0]];

    // Write-side pointer and overflow flag.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            ovf_w <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                ovf_w <= 1'b1;
            end else begin
                wbin  <= wbin_nx;
                wgray <= (wbin_nx >> 1) ^ wbin_nx;
            end
        end
    end

    // Storage write.
    always_ff @(posedge wclk) begin
        if (rst_n && wr_en && !full) mem[wbin[AW-1:0]] <= wdata;
    end

    // Read-side pointer.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en && !empty) begin
            rbin  <= rbin_nx;
            rgray <= (rbin_nx >> 1) ^ rbin_nx;
        end
    end

    txin_sync2 #(.WIDTH(AW+1)) u_rsync (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
    txin_sync2 #(.WIDTH(AW+1)) u_wsync (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
    txin_sync2 #(.WIDTH(1))    u_osync (.clk(rclk), .rst_n(rst_n), .d(ovf_w), .q(ovf));

    assert_no_write_when_full_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wbin));

    assert_no_pop_when_empty_R10: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rbin));
endmodule

// File: rtl/txin_stage.sv
// Transmit character capture for LANES lanes, with mode decoding.
// In shared-clock mode, inputs are registered on clk.
// In per-lane mode, each lane writes its own FIFO, and all FIFOs are read together on clk once every lane holds data.
// Assumes split_clk and tx_mode are static while streaming in per-lane mode.
module txin_stage
    import txin_pkg::*;
#(
    parameter int LANES  = TXIN_LANES,
    parameter int DEPTH  = TXIN_DEPTH,
    parameter int DATA_W = TXIN_DATA_W,
    parameter int CTL_W  = TXIN_CTL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       split_clk,
    input  logic [1:0]                 tx_mode,
    input  logic [LANES-1:0]           lane_clk,
    input  logic [LANES*DATA_W-1:0]    lane_data,
    input  logic [LANES*CTL_W-1:0]     lane_ctl,
    input  logic                       sel_in,
    output logic                       out_valid,
    output logic [LANES*(DATA_W+CTL_W)-1:0] out_word,
    output logic                       out_sel,
    output logic                       out_bypass,
    output logic [LANES-1:0]           fifo_err
);
    localparam int CHAR_W = DATA_W + CTL_W;

    logic [CHAR_W-1:0] in_char [LANES];
    logic [CHAR_W-1:0] head    [LANES];
    logic [LANES-1:0]  nonempty, ovf_r, udf_q;
    logic              head_sel, primed_q, all_ready, rd_all, load, sel_src;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic emp;
        assign in_char[g]  = {lane_ctl[g*CTL_W +: CTL_W], lane_data[g*DATA_W +: DATA_W]};
        assign nonempty[g] = ~emp;
        if (g == 0) begin : g_with_sel
            logic [CHAR_W:0] rd;
            txin_lane_fifo #(.WIDTH(CHAR_W+1), .DEPTH(DEPTH)) u_fifo (
                .wclk(lane_clk[g]), .rclk(clk), .rst_n(rst_n), .wr_en(split_clk),
                .wdata({sel_in, in_char[g]}), .rd_en(rd_all), .rdata(rd),
                .empty(emp), .ovf(ovf_r[g]));
            assign head[g]  = rd[CHAR_W-1:0];
            assign head_sel = rd[CHAR_W];
        end else begin : g_plain
            txin_lane_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_fifo (
                .wclk(lane_clk[g]), .rclk(clk), .rst_n(rst_n), .wr_en(split_clk),
                .wdata(in_char[g]), .rd_en(rd_all), .rdata(head[g]),
                .empty(emp), .ovf(ovf_r[g]));
        end
    end

    assign all_ready = &nonempty;
    assign rd_all    = split_clk & primed_q & all_ready;
    assign load      = split_clk ? rd_all : 1'b1;
    assign sel_src   = split_clk ? head_sel : sel_in;
    assign fifo_err  = udf_q | ovf_r;

    // Streaming starts the first time every lane holds data.
    always_ff @(posedge clk) begin
        if (!rst_n)                       primed_q <= 1'b0;
        else if (split_clk && all_ready)  primed_q <= 1'b1;
    end

    // Sticky underflow: a lane is empty while streaming is due.
    always_ff @(posedge clk) begin
        if (!rst_n)                      udf_q <= '0;
        else if (split_clk && primed_q)  udf_q <= udf_q | ~nonempty;
    end

    // Output register: characters, select bit and mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_word   <= '0;
            out_sel    <= 1'b0;
            out_bypass <= 1'b0;
        end else begin
            out_valid  <= load;
            out_bypass <= ~encoder_on(tx_mode);
            out_sel    <= select_on(tx_mode) & (load ? sel_src : out_sel);
            if (load) begin
                for (int i = 0; i < LANES; i++)
                    out_word[i*CHAR_W +: CHAR_W] <= split_clk ? head[i] : in_char[i];
            end
        end
    end

    assert_bypass_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode[1] |=> out_bypass);

    assert_encode_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode[1] |=> !out_bypass);

    assert_sel_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode[0] |=> !out_sel);

    assert_stall_without_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (split_clk && !all_ready) |=> !out_valid);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err != '0) |=> (($past(fifo_err) & ~fifo_err) == '0));
endmodule

// File: tb/txin_stage_bench.sv
`timescale 1ns/1ps
module txin_stage_bench;
    localparam int LANES = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              split_clk = 1'b0;
    logic [1:0]        tx_mode = 2'b10;
    logic [LANES-1:0]  lane_run = '1;
    logic [LANES-1:0]  lane_clk;
    logic [LANES*8-1:0] lane_data;
    logic [LANES*2-1:0] lane_ctl;
    logic              sel_in;
    logic              use_cnt = 1'b0;
    logic [7:0]        man_data [LANES];
    logic [1:0]        man_ctl  [LANES];
    logic              man_sel = 1'b0;
    logic              out_valid, out_sel, out_bypass;
    logic [LANES*10-1:0] out_word;
    logic [LANES-1:0]  fifo_err;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Per-lane clock, counter and input drive
    for (genvar g = 0; g < LANES; g++) begin : g_src
        logic       ph = 1'b0;
        logic [15:0] c = '0;
        initial begin
            #(1 + 2*g + ((g >= 2) ? 2 : 0));
            forever #5 ph = ~ph;
        end
        assign lane_clk[g] = ph & lane_run[g];
        initial begin
            forever begin
                @(posedge lane_clk[g]);
                if (rst_n) begin #1; c = c + 16'd1; end
                else c = '0;
            end
        end
        assign lane_data[g*8 +: 8] = use_cnt ? (c[7:0] + 8'(16*g)) : man_data[g];
        assign lane_ctl[g*2 +: 2]  = use_cnt ? 2'(c + 16'(g)) : man_ctl[g];
        if (g == 0) begin : g_sel
            assign sel_in = use_cnt ? c[0] : man_sel;
        end
    end

    txin_stage u_txin_stage (
        .clk(clk), .rst_n(rst_n), .split_clk(split_clk), .tx_mode(tx_mode),
        .lane_clk(lane_clk), .lane_data(lane_data), .lane_ctl(lane_ctl), .sel_in(sel_in),
        .out_valid(out_valid), .out_word(out_word), .out_sel(out_sel),
        .out_bypass(out_bypass), .fifo_err(fifo_err));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic split, input logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0; lane_run = '1; split_clk = split; tx_mode = mode;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 2'b00);
        check("R8 out_valid in reset", 64'(out_valid), 64'd0);
        check("R8 out_word in reset", 64'(out_word), 64'd0);
        check("R8 sel/bypass in reset", 64'({out_sel, out_bypass}), 64'd0);
        check("R8 fifo_err in reset", 64'(fifo_err), 64'd0);
    endtask

    task automatic t_shared_capture();
        logic [39:0] exp;
        do_reset(1'b0, 2'b10);
        rst_n = 1'b1;
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            for (int i = 0; i < LANES; i++) begin
                man_data[i] = 8'(8'h3C * (p + 1) + 8'(i * 7));
                man_ctl[i]  = 2'(p + i);
                exp[i*10 +: 10] = {2'(p + i), 8'(8'h3C * (p + 1) + 8'(i * 7))};
            end
            man_sel = p[0];
            @(posedge clk); #1;
            check("R1 shared word", 64'(out_word), 64'(exp));
            check("R1 shared valid", 64'(out_valid), 64'd1);
            check("R3 encode flag", 64'(out_bypass), 64'd0);
            check("R4 sel per cycle", 64'(out_sel), 64'(p[0]));
        end
    endtask

    task automatic t_bypass();
        @(negedge clk);
        tx_mode = 2'b00; man_ctl[2] = 2'b11; man_data[2] = 8'hA5; man_sel = 1'b1;
        @(posedge clk); #1;
        check("R2 bypass flag", 64'(out_bypass), 64'd1);
        check("R2 preencoded char lane2", 64'(out_word[29:20]), 64'h3A5);
        check("R4 sel with bypass", 64'(out_sel), 64'd1);
    endtask

    task automatic t_sel_mask();
        @(negedge clk);
        tx_mode = 2'b11; man_sel = 1'b1;
        @(posedge clk); #1;
        check("R5 sel forced low", 64'(out_sel), 64'd0);
        @(negedge clk);
        tx_mode = 2'b10;
        @(posedge clk); #1;
        check("R4 sel restored", 64'(out_sel), 64'd1);
    endtask

    task automatic t_split_stream();
        int nvalid = 0;
        int bad6 = 0;
        int bad7 = 0;
        logic [7:0] prev = '0;
        logic [7:0] d0;
        do_reset(1'b1, 2'b10);
        use_cnt = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 no output before data", 64'(out_valid), 64'd0);
        repeat (20) @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (out_valid) begin
                d0 = out_word[7:0];
                for (int i = 0; i < LANES; i++)
                    if (out_word[i*10 +: 10] !== {2'(d0 + 8'(i)), 8'(d0 + 8'(16*i))}) bad6++;
                if (nvalid > 0 && d0 !== 8'(prev + 8'd1)) bad6++;
                if (out_sel !== d0[0]) bad7++;
                prev = d0;
                nvalid++;
            end
        end
        check("R6 continuous stream", 64'(nvalid), 64'd40);
        check("R6 lanes aligned in order", 64'(bad6), 64'd0);
        check("R7 sel travels with lane0 char", 64'(bad7), 64'd0);
        check("R9 no errors while streaming", 64'(fifo_err), 64'd0);
    endtask

    task automatic t_overflow();
        int seen = 0;
        do_reset(1'b1, 2'b10);
        lane_run[2] = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check("R9 overflow on running lanes", 64'(fifo_err), 64'hB);
        check("R6 no output with lane starved", 64'(seen), 64'd0);
        repeat (10) @(negedge clk);
        check("R9 overflow flag sticky", 64'(fifo_err), 64'hB);
    endtask

    task automatic t_underflow();
        do_reset(1'b1, 2'b10);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check("R10 streaming before stop", 64'({out_valid, fifo_err}), 64'h10);
        lane_run[1] = 1'b0;
        repeat (20) @(negedge clk);
        check("R10 underflow flag lane1", 64'(fifo_err[1]), 64'd1);
        check("R10 output stalls", 64'(out_valid), 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < LANES; i++) begin man_data[i] = '0; man_ctl[i] = '0; end
        t_reset();
        t_shared_capture();
        t_bypass();
        t_sel_mask();
        t_split_stream();
        t_overflow();
        t_underflow();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule